// File: doc/BRIEF.md
# Flash Read Accelerator with Sequential Prefetch

This block sits between a 32-bit fetch port and a wide, slow on-chip flash array. Requestors issue 8-, 16- or 32-bit reads; the block fetches whole flash lines, keeps them in two line buffers and returns the addressed bytes from there. When a run of fetches is under way, one buffer serves the requestor while the following line is fetched into the other buffer. At zero wait states, a linear code stream then sees one word per cycle after the first miss.

Three configuration inputs are sampled every cycle: a wait-state count (extra cycles per flash line read), a line-width select (16-byte lines by default, 8-byte lines when narrow mode is set) and a sequential-disable flag. When that flag is set, every read goes to flash and nothing is prefetched. Any change to these inputs drops both buffers and abandons a fetch in flight. The flash occupies only the low `FLASH_BYTES` of the request address window. Higher address bits are ignored, so its contents repeat across the window.

The control is a three-state machine. **IDLE** serves hits and decides what comes next. **DEMAND** fetches a line a requestor is stalled on. **PREFETCH** fetches the line following the most recently used one. The named transitions are:

- **T_MISS** (IDLE to DEMAND, on a request that hits neither buffer).
- **T_PF_START** (IDLE to PREFETCH, when the next sequential line is absent).
- **T_DEM_DONE** (DEMAND to IDLE, when the line lands in buffer 0).
- **T_PF_DONE** (PREFETCH to IDLE, when the line lands in the other buffer).
- **T_PF_ABORT** (PREFETCH to DEMAND, on a miss to any line other than the one being prefetched).
- **T_CFG_ABORT** (any state to IDLE, on a configuration change).

Top module: `flash_read_accel`

## Requirements
- R1: Out of reset `rsp_valid`, `fl_rd` and `req_ready` are low.
- R2: A request that misses while the block is IDLE or prefetching another line keeps `req_ready` low for exactly `cfg_wait`+2 cycles and is accepted in the following cycle. During that time the flash line read holds `fl_addr` stable for `cfg_wait`+1 cycles.
- R3: `req_size` encodes 0 = byte, 1 = halfword, 2 = word; requests are naturally aligned. The addressed bytes are returned little-endian in the low lanes of `rsp_data`, and the unused upper lanes are zero.
- R4: A request that hits a valid buffer sees `req_ready` high in the cycle it is presented. `rsp_valid` is high with the data in the cycle after acceptance.
- R5: In the default 16-byte line mode, after a demand miss the next 16-byte line is prefetched into the other buffer. With `cfg_wait` = 0, a linear run of word reads is accepted with no stall after the first miss.
- R6: With `cfg_narrow` = 1, lines are 8 bytes. Prefetch covers only the next 8 bytes, and a linear run of word reads at `cfg_wait` = 0 still streams with no stall after the first miss.
- R7: With `cfg_seq_off` = 1, every read, including a repeat of the previous address, takes the full miss latency of R2, and no prefetch is started.
- R8: Address bits at and above log2(`FLASH_BYTES`) are ignored. An aliased address hits a line buffered under another alias and returns the same data, and the prefetch after the last line wraps to line 0.
- R9: A buffered line, and a completed prefetch, stay valid across any number of idle cycles.
- R10: A non-sequential miss invalidates both buffers and abandons a prefetch in flight. A request issued right after it to the previously prefetched line misses.
- R11: A change of `cfg_wait`, `cfg_narrow` or `cfg_seq_off` invalidates both buffers and aborts any fetch in flight. A line whose prefetch was interrupted must then be fetched again.
- R12: A request to the line currently being prefetched waits for that prefetch without starting a new one. `req_ready` stays low for the prefetch cycles that remain, which is `cfg_wait`+1 when the request arrives in the cycle after the prefetch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait | input | WS_W | Flash wait states per line read |
| cfg_narrow | input | 1 | 1 = 8-byte lines, 0 = 16-byte lines |
| cfg_seq_off | input | 1 | 1 = buffering and prefetch disabled |
| req_valid | input | 1 | Read request present (held until accepted) |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_ready | output | 1 | Request accepted this cycle when high together with `req_valid` |
| rsp_valid | output | 1 | Read data valid (cycle after acceptance) |
| rsp_data | output | 32 | Read data, low lanes, zero-extended |
| fl_rd | output | 1 | Flash line read in progress |
| fl_addr | output | log2(FLASH_BYTES) | Byte address of the flash line being read |
| fl_wide | output | 1 | High when a 16-byte line is read |
| fl_rdata | input | 128 | Flash line data (byte 0 in bits 7:0) |

## Verification
The hardest situation to reach from the ports is a configuration change that lands while a prefetch is still in flight. The change must cancel that prefetch, so that the line it was filling is not left marked valid. The stimulus sets seven wait states so that the prefetch lasts eight cycles. It lets the demand read complete, changes the wait count three cycles into the prefetch, and then asks for the line that was being prefetched; the stall that follows must be a full miss. The same timing method covers a request that arrives right behind a non-sequential miss, and a request for the line being prefetched, which must wait only for the cycles that remain.

// File: rtl/fra_pkg.sv
package fra_pkg;

    localparam int LINE_BITS = 128;
    localparam int NBUF      = 2;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DEMAND   = 2'd1,
        ST_PREFETCH = 2'd2
    } fra_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } fra_size_e;

endpackage

// File: rtl/fra_line_buf.sv
module fra_line_buf
    import fra_pkg::*;
#(
    parameter int FL_AW = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           narrow,
    input  logic [FL_AW-1:0]               lookup_off,
    input  logic                           inval_all,
    input  logic                           inval_one,
    input  logic                           inval_idx,
    input  logic                           load_en,
    input  logic                           load_idx,
    input  logic [FL_AW-1:0]               load_tag,
    input  logic [LINE_BITS-1:0]           load_data,
    output logic                           hit,
    output logic                           hit_idx,
    output logic [LINE_BITS-1:0]           hit_line,
    output logic [NBUF-1:0]                buf_valid,
    output logic [NBUF-1:0][FL_AW-1:0]     buf_tag
);

    logic [NBUF-1:0][LINE_BITS-1:0] buf_data;
    logic [NBUF-1:0]                match;
    logic [FL_AW-1:0]               line_mask;
    logic [FL_AW-1:0]               lookup_base;

    assign line_mask   = narrow ? FL_AW'(7) : FL_AW'(15);
    assign lookup_base = lookup_off & ~line_mask;

    for (genvar g = 0; g < NBUF; g++) begin : g_entry
        assign match[g] = buf_valid[g] && (buf_tag[g] == lookup_base);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                buf_valid[g] <= 1'b0;
                buf_tag[g]   <= '0;
                buf_data[g]  <= '0;
            end else begin
                if (inval_all || (inval_one && (inval_idx == 1'(g)))) begin
                    buf_valid[g] <= 1'b0;
                end
                if (load_en && (load_idx == 1'(g))) begin
                    buf_valid[g] <= 1'b1;
                    buf_tag[g]   <= load_tag;
                    buf_data[g]  <= load_data;
                end
            end
        end
    end

    assign hit      = |match;
    assign hit_idx  = match[1];
    assign hit_line = buf_data[hit_idx];

    // R10: the two buffers never hold the same valid line at once
    assert_dup_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/fra_extract.sv
module fra_extract
    import fra_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic [LINE_BITS-1:0] line,
    input  logic [3:0]           byte_off,
    input  logic [1:0]           size,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_data
);

    logic [31:0] word_sel;
    logic [31:0] sized;
    logic [1:0]  size_q;

    assign word_sel = 32'(line >> {byte_off, 3'b000});

    always_comb begin
        unique case (fra_size_e'(size))
            SZ_BYTE: sized = {24'd0, word_sel[7:0]};
            SZ_HALF: sized = {16'd0, word_sel[15:0]};
            default: sized = word_sel;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            size_q    <= '0;
        end else begin
            rsp_valid <= take;
            size_q    <= size;
            if (take) begin
                rsp_data <= sized;
            end
        end
    end

    // R3: a byte response carries nothing in the upper lanes
    assert_byte_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && size_q == SZ_BYTE) |-> (rsp_data[31:8] == 24'd0));

endmodule

// File: rtl/fra_ctrl.sv
module fra_ctrl
    import fra_pkg::*;
#(
    parameter int FL_AW = 12,
    parameter int WS_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WS_W-1:0]            cfg_wait,
    input  logic                       cfg_narrow,
    input  logic                       cfg_seq_off,
    input  logic                       req_valid,
    input  logic [FL_AW-1:0]           req_off,
    input  logic                       hit,
    input  logic                       hit_idx,
    input  logic [NBUF-1:0]            buf_valid,
    input  logic [NBUF-1:0][FL_AW-1:0] buf_tag,
    output logic                       req_ready,
    output logic                       accept,
    output logic                       fl_rd,
    output logic [FL_AW-1:0]           fl_addr,
    output logic                       fl_wide,
    output logic                       inval_all,
    output logic                       inval_one,
    output logic                       inval_idx,
    output logic                       load_en,
    output logic                       load_idx,
    output logic [FL_AW-1:0]           load_tag
);

    fra_state_e       state, state_nx;
    logic [WS_W-1:0]  cnt, cnt_nx;
    logic [FL_AW-1:0] fetch_tag, tag_nx;
    logic             pf_idx, pf_idx_nx;
    logic             mru, mru_nx, mru_reg_nx;

    logic [WS_W-1:0]  wait_q;
    logic             narrow_q, seq_off_q;
    logic             cfg_chg;

    logic [FL_AW-1:0] line_mask, req_base, step, next_line;
    logic             miss, need_pf, pf_target;

    assign cfg_chg   = (cfg_wait != wait_q) || (cfg_narrow != narrow_q)
                     || (cfg_seq_off != seq_off_q);
    assign line_mask = cfg_narrow ? FL_AW'(7) : FL_AW'(15);
    assign step      = cfg_narrow ? FL_AW'(8) : FL_AW'(16);
    assign req_base  = req_off & ~line_mask;

    assign req_ready = hit && !cfg_chg;
    assign accept    = req_valid && req_ready;
    assign miss      = req_valid && !hit;
    assign mru_nx    = accept ? hit_idx : mru;
    assign next_line = buf_tag[mru_nx] + step;
    assign need_pf   = !cfg_seq_off && buf_valid[mru_nx]
                     && !(buf_valid[~mru_nx] && (buf_tag[~mru_nx] == next_line));
    assign pf_target = (state == ST_PREFETCH) && (req_base == fetch_tag);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            fetch_tag <= '0;
            pf_idx    <= 1'b0;
            mru       <= 1'b0;
            wait_q    <= '0;
            narrow_q  <= 1'b0;
            seq_off_q <= 1'b0;
        end else begin
            state     <= state_nx;
            cnt       <= cnt_nx;
            fetch_tag <= tag_nx;
            pf_idx    <= pf_idx_nx;
            mru       <= mru_reg_nx;
            wait_q    <= cfg_wait;
            narrow_q  <= cfg_narrow;
            seq_off_q <= cfg_seq_off;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx   = state;
        cnt_nx     = cnt;
        tag_nx     = fetch_tag;
        pf_idx_nx  = pf_idx;
        mru_reg_nx = mru_nx;
        inval_all  = 1'b0;
        inval_one  = 1'b0;
        load_en    = 1'b0;
        load_idx   = pf_idx;
        if (cfg_chg) begin
            // T_CFG_ABORT
            state_nx  = ST_IDLE;
            inval_all = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (miss) begin
                        // T_MISS
                        state_nx  = ST_DEMAND;
                        cnt_nx    = cfg_wait;
                        tag_nx    = req_base;
                        inval_all = 1'b1;
                    end else begin
                        if (cfg_seq_off && accept) begin
                            inval_all = 1'b1;
                        end
                        if (need_pf) begin
                            // T_PF_START
                            state_nx  = ST_PREFETCH;
                            cnt_nx    = cfg_wait;
                            tag_nx    = next_line;
                            pf_idx_nx = ~mru_nx;
                            inval_one = 1'b1;
                        end
                    end
                end
                ST_DEMAND: begin
                    if (cnt == '0) begin
                        // T_DEM_DONE
                        state_nx   = ST_IDLE;
                        load_en    = 1'b1;
                        load_idx   = 1'b0;
                        mru_reg_nx = 1'b0;
                    end else begin
                        cnt_nx = cnt - 1'b1;
                    end
                end
                ST_PREFETCH: begin
                    if (miss && !pf_target) begin
                        // T_PF_ABORT
                        state_nx  = ST_DEMAND;
                        cnt_nx    = cfg_wait;
                        tag_nx    = req_base;
                        inval_all = 1'b1;
                    end else if (cnt == '0) begin
                        // T_PF_DONE
                        state_nx = ST_IDLE;
                        load_en  = 1'b1;
                    end else begin
                        cnt_nx = cnt - 1'b1;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    assign inval_idx = pf_idx_nx;
    assign load_tag  = fetch_tag;
    assign fl_rd     = (state != ST_IDLE);
    assign fl_addr   = fetch_tag;
    assign fl_wide   = !cfg_narrow;

    // R2: a requestor waiting on a demand fetch is held off
    assert_demand_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEMAND) |-> !req_ready);

    // R2: the flash line address holds while a read counts down
    assert_hold_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) == state && $past(cnt) != '0)
        |-> $stable(fl_addr));

    // R11: a configuration change leaves no buffer valid
    assert_cfg_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (buf_valid == '0 && state == ST_IDLE));

    // R7: no prefetch runs while sequential buffering is off
    assert_no_prefetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_seq_off && $past(cfg_seq_off)) |-> (state != ST_PREFETCH));

endmodule

// File: rtl/flash_read_accel.sv
module flash_read_accel
    import fra_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int FLASH_BYTES = 4096,
    parameter int WS_W        = 4,
    localparam int FL_AW      = $clog2(FLASH_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WS_W-1:0]      cfg_wait,
    input  logic                 cfg_narrow,
    input  logic                 cfg_seq_off,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_data,
    output logic                 fl_rd,
    output logic [FL_AW-1:0]     fl_addr,
    output logic                 fl_wide,
    input  logic [LINE_BITS-1:0] fl_rdata
);

    logic [FL_AW-1:0]           req_off;
    logic                       hit, hit_idx, accept;
    logic [LINE_BITS-1:0]       hit_line;
    logic [NBUF-1:0]            buf_valid;
    logic [NBUF-1:0][FL_AW-1:0] buf_tag;
    logic                       inval_all, inval_one, inval_idx;
    logic                       load_en, load_idx;
    logic [FL_AW-1:0]           load_tag;
    logic [3:0]                 byte_off;

    assign req_off  = req_addr[FL_AW-1:0];
    assign byte_off = req_off[3:0] & (cfg_narrow ? 4'h7 : 4'hF);

    fra_ctrl #(.FL_AW(FL_AW), .WS_W(WS_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wait    (cfg_wait),
        .cfg_narrow  (cfg_narrow),
        .cfg_seq_off (cfg_seq_off),
        .req_valid   (req_valid),
        .req_off     (req_off),
        .hit         (hit),
        .hit_idx     (hit_idx),
        .buf_valid   (buf_valid),
        .buf_tag     (buf_tag),
        .req_ready   (req_ready),
        .accept      (accept),
        .fl_rd       (fl_rd),
        .fl_addr     (fl_addr),
        .fl_wide     (fl_wide),
        .inval_all   (inval_all),
        .inval_one   (inval_one),
        .inval_idx   (inval_idx),
        .load_en     (load_en),
        .load_idx    (load_idx),
        .load_tag    (load_tag)
    );

    fra_line_buf #(.FL_AW(FL_AW)) bufs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .narrow     (cfg_narrow),
        .lookup_off (req_off),
        .inval_all  (inval_all),
        .inval_one  (inval_one),
        .inval_idx  (inval_idx),
        .load_en    (load_en),
        .load_idx   (load_idx),
        .load_tag   (load_tag),
        .load_data  (fl_rdata),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .hit_line   (hit_line),
        .buf_valid  (buf_valid),
        .buf_tag    (buf_tag)
    );

    fra_extract extract_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (accept),
        .line      (hit_line),
        .byte_off  (byte_off),
        .size      (req_size),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    // R8: a request through an upper alias is served like any other
    assert_alias_served_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_addr[ADDR_W-1:FL_AW] != '0)) |=> rsp_valid);

endmodule

// File: tb/flash_read_accel_tb_top.sv
module flash_read_accel_tb_top;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 24;
    localparam int FB     = 4096;
    localparam int WS_W   = 4;
    localparam int FL_AW  = $clog2(FB);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WS_W-1:0]   cfg_wait = '0;
    logic              cfg_narrow = 1'b0;
    logic              cfg_seq_off = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = 2'd2;
    logic              req_ready, rsp_valid, fl_rd, fl_wide;
    logic [31:0]       rsp_data;
    logic [FL_AW-1:0]  fl_addr;
    logic [127:0]      fl_rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] fbyte(int a);
        int m = a % FB;
        return 8'((m * 13) + (m >> 4) + 8'h5A);
    endfunction

    always_comb begin
        for (int i = 0; i < 16; i++) begin
            fl_rdata[8*i +: 8] = fbyte(int'(fl_addr) + i);
        end
    end

    flash_read_accel #(.ADDR_W(ADDR_W), .FLASH_BYTES(FB), .WS_W(WS_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wait    (cfg_wait),
        .cfg_narrow  (cfg_narrow),
        .cfg_seq_off (cfg_seq_off),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .fl_rd       (fl_rd),
        .fl_addr     (fl_addr),
        .fl_wide     (fl_wide),
        .fl_rdata    (fl_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_data(int addr, int size);
        logic [31:0] d = '0;
        int nb = (size == 0) ? 1 : (size == 1) ? 2 : 4;
        for (int i = 0; i < nb; i++) begin
            d[8*i +: 8] = fbyte(addr + i);
        end
        return d;
    endfunction

    // Presents a request at a falling edge, counts stall cycles, checks
    // the stall count and the response one cycle after acceptance (R4).
    task automatic do_read(input int addr, input int size, input int exp_wait,
                           input string req);
        int waits = 0;
        req_valid = 1'b1;
        req_addr  = ADDR_W'(addr);
        req_size  = 2'(size);
        #1;
        while (!req_ready && waits < 300) begin
            @(negedge clk);
            #1;
            waits++;
        end
        @(negedge clk);
        chk(waits == exp_wait, req, $sformatf("stall @%0h", addr), waits, exp_wait);
        chk(rsp_valid == 1'b1, "R4", $sformatf("rsp_valid @%0h", addr), rsp_valid, 1);
        chk(rsp_data == exp_data(addr, size), req, $sformatf("data @%0h", addr),
            rsp_data, exp_data(addr, size));
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input int w, input bit nar, input bit off);
        req_valid   = 1'b0;
        cfg_wait    = WS_W'(w);
        cfg_narrow  = nar;
        cfg_seq_off = off;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
        chk(fl_rd == 1'b0, "R1", "fl_rd in reset", fl_rd, 0);
        chk(req_ready == 1'b0, "R1", "req_ready in reset", req_ready, 0);
    endtask

    task automatic t_miss_then_hit();
        set_cfg(2, 0, 0);
        do_read(32'h40, 2, 4, "R2");
        do_read(32'h44, 2, 0, "R4");
    endtask

    task automatic t_sizes();
        do_read(32'h41, 0, 0, "R3");
        do_read(32'h42, 1, 0, "R3");
        do_read(32'h4F, 0, 0, "R3");
        do_read(32'h4E, 1, 0, "R3");
        do_read(32'h48, 2, 0, "R3");
    endtask

    task automatic t_wide_stream();
        set_cfg(0, 0, 0);
        do_read(32'h100, 2, 2, "R5");
        for (int a = 32'h104; a < 32'h140; a += 4) begin
            do_read(a, 2, 0, "R5");
        end
        idle(3);
    endtask

    task automatic t_narrow();
        set_cfg(0, 1, 0);
        do_read(32'h200, 2, 2, "R6");
        for (int a = 32'h204; a < 32'h240; a += 4) begin
            do_read(a, 2, 0, "R6");
        end
        idle(3);
        do_read(32'h300, 2, 2, "R6");
        idle(5);
        do_read(32'h314, 2, 2, "R6");
        set_cfg(0, 0, 0);
        do_read(32'h300, 2, 2, "R5");
        idle(10);
        do_read(32'h314, 2, 0, "R5");
        idle(2);
    endtask

    task automatic t_seq_off();
        set_cfg(1, 0, 1);
        do_read(32'h80, 2, 3, "R7");
        do_read(32'h80, 2, 3, "R7");
        do_read(32'h84, 2, 3, "R7");
        idle(4);
        do_read(32'h88, 0, 3, "R7");
        idle(2);
    endtask

    task automatic t_wrap();
        set_cfg(1, 0, 0);
        do_read(32'h50, 2, 3, "R8");
        do_read(32'h50 + 3 * FB, 2, 0, "R8");
        do_read(32'h5FF0 + 4 * FB, 2, 3, "R8");
        idle(5);
        do_read(32'h0, 2, 0, "R8");
        idle(2);
    endtask

    task automatic t_idle_keep();
        set_cfg(3, 0, 0);
        do_read(32'h400, 2, 5, "R9");
        idle(30);
        do_read(32'h404, 2, 0, "R9");
        do_read(32'h410, 2, 0, "R9");
        idle(2);
    endtask

    task automatic t_nonseq_inval();
        set_cfg(3, 0, 0);
        do_read(32'h500, 2, 5, "R10");
        idle(10);
        do_read(32'h900, 2, 5, "R10");
        do_read(32'h510, 2, 5, "R10");
        idle(2);
    endtask

    task automatic t_cfg_change();
        set_cfg(7, 0, 0);
        do_read(32'h600, 2, 9, "R11");
        idle(2);
        set_cfg(6, 0, 0);
        do_read(32'h610, 2, 8, "R11");
        set_cfg(2, 0, 0);
        do_read(32'h700, 2, 4, "R11");
        idle(5);
        set_cfg(3, 0, 0);
        do_read(32'h700, 2, 5, "R11");
        idle(2);
    endtask

    task automatic t_pf_wait();
        set_cfg(5, 0, 0);
        do_read(32'hA00, 2, 7, "R12");
        do_read(32'hA10, 2, 6, "R12");
        do_read(32'hA14, 2, 0, "R12");
        idle(2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_miss_then_hit();
        t_sizes();
        t_wide_stream();
        t_narrow();
        t_seq_off();
        t_wrap();
        t_idle_keep();
        t_nonseq_inval();
        t_cfg_change();
        t_pf_wait();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule